// File: doc/BRIEF.md
# Weighted-Average Defuzzifier With Reciprocal Divider

This block closes the inference path of a zero-order rule-based fuzzy controller. Each clock it may accept one active rule: an unsigned 8-bit firing strength and a signed 12-bit singleton consequent. Over a group of 16 rules it keeps two running sums. One is the signed sum of strength times consequent, the dividend. The other is the unsigned sum of strengths, the divisor.

When the sixteenth rule of a group has been taken, the block forms the weighted average. It reads a 22-bit rounded reciprocal of the divisor from a table that is computed at elaboration. It then does one signed multiplication and keeps the integer part, with no iteration. Two detectors cover the cases the table does not hold. A divisor of zero means no rule fired. A divisor of one passes the dividend straight through, so the table stays 22 bits wide. The result is clamped to the signed 12-bit range and marked by a one-clock ready pulse.

Top module: `wavg_defuzz`

## Requirements
- R1: While reset is high, and after it is released until the first result, out_ready is 0 and out_result is 0.
- R2: A group starts at an accepted rule whose in_first is 1, or at the first accepted rule after 16 rules have completed a group. Both running sums restart from that rule, and a started group is abandoned when in_first is seen again.
- R3: Only cycles with in_valid high are accepted as rules. The dividend is the signed sum of in_weight × in_single (25 bits), and the divisor is the sum of in_weight (12 bits, at most 16 × 255).
- R4: out_result and out_ready change 3 clocks after the edge that accepts the sixteenth rule. out_ready is high for exactly one clock, and out_result holds its value until the next group's result.
- R5: A divisor of 0 gives out_result = 12'hFFF (−1).
- R6: A divisor of 1 gives out_result equal to the dividend.
- R7: For a divisor d ≥ 2, out_result is floor(dividend × R / 2^22), where R = floor((2^23 + d) / (2 × d)), that is 2^22/d rounded half up.
- R8: A quotient outside −2048..2047 is clamped to the nearer limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A rule is presented this cycle |
| in_first | input | 1 | This rule opens a new group |
| in_weight | input | 8 | Unsigned firing strength |
| in_single | input | 12 | Signed singleton consequent |
| out_result | output | 12 | Signed weighted average |
| out_ready | output | 1 | One-clock pulse when out_result is new |

## Verification
A corrupted running sum does not stay hidden. It shows up in the very next result, 3 clocks after the group's last rule, as a quotient that differs from the independently computed average. A stale or wrong rule counter shows as a ready pulse that is early, late, missing or doubled, and every group checks the ready line at each of those cycles. A wrong reciprocal entry or detector shows only for divisors that reach it, so the vectors spread divisors from 0, 1 and 5 up to 4080, and include exact, truncating and clamping quotients.

// File: rtl/dfz_pkg.sv
package dfz_pkg;

  // Path chosen for a finished group's quotient
  typedef enum logic [1:0] {
    DK_TABLE = 2'd0,
    DK_ZERO  = 2'd1,
    DK_ONE   = 2'd2
  } dk_e;

  // Reciprocal 2^frac / d, rounded half up; entries below 2 are unused
  function automatic longint recip_val(input longint d, input int frac);
    longint num;
    if (d < 2) return 0;
    num = longint'(1) <<< (frac + 1);
    return (num + d) / (2 * d);
  endfunction

endpackage

// File: rtl/dfz_integ.sv
module dfz_integ #(
  parameter int W_WT  = 8,
  parameter int W_SG  = 12,
  parameter int RULES = 16,
  parameter int W_DVD = W_WT + 1 + W_SG + $clog2(RULES),
  parameter int W_DVS = W_WT + $clog2(RULES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid,
  input  logic                    first,
  input  logic [W_WT-1:0]         weight,
  input  logic signed [W_SG-1:0]  single,
  output logic signed [W_DVD-1:0] dvd,
  output logic [W_DVS-1:0]        dvs,
  output logic                    done
);
  localparam int W_TERM = W_WT + 1 + W_SG;
  localparam int W_CNT  = (RULES > 1) ? $clog2(RULES) : 1;
  localparam logic [W_CNT-1:0] LAST_IDX = W_CNT'(RULES - 1);

  logic [W_CNT-1:0]         cnt;
  logic [W_CNT-1:0]         idx;
  logic                     start;
  logic                     last;
  logic signed [W_TERM-1:0] term;

  always_comb begin
    term  = $signed({1'b0, weight}) * single;
    start = first || (cnt == '0);
    idx   = first ? '0 : cnt;
    last  = valid && (idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      dvd  <= '0;
      dvs  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (valid) begin
        cnt <= last ? '0 : idx + 1'b1;
        dvd <= (start ? '0 : dvd) + W_DVD'(term);
        dvs <= (start ? '0 : dvs) + W_DVS'(weight);
      end
    end
  end

  // R3: the strength sum never exceeds a full group of maximum strengths
  a_r3_divisor_bound: assert property (@(posedge clk) disable iff (rst)
    32'(dvs) <= RULES * (2**W_WT - 1));

  // R2: a group is closed only by an accepted rule
  a_r2_done_needs_rule: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(valid));

endmodule

// File: rtl/dfz_recip_rom.sv
module dfz_recip_rom #(
  parameter int W_ADDR = 12,
  parameter int W_DATA = 22
) (
  input  logic              clk,
  input  logic [W_ADDR-1:0] addr,
  output logic [W_DATA-1:0] rdata
);
  localparam int DEPTH = 2**W_ADDR;

  logic [W_DATA-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = W_DATA'(dfz_pkg::recip_val(longint'(i), W_DATA));
  end

  // Registered read, no reset, so block RAM can hold the table
  always_ff @(posedge clk)
    rdata <= mem[addr];

endmodule

// File: rtl/dfz_divider.sv
module dfz_divider #(
  parameter int W_DVD = 25,
  parameter int W_DVS = 12,
  parameter int W_RCP = 22,
  parameter int W_OUT = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [W_DVD-1:0] dvd,
  input  logic [W_DVS-1:0]        dvs,
  input  logic                    done,
  output logic signed [W_OUT-1:0] result,
  output logic                    ready
);
  import dfz_pkg::*;

  localparam int W_PROD = W_DVD + W_RCP + 1;
  localparam int W_Q    = W_PROD - W_RCP;
  localparam logic signed [W_Q-1:0] Q_MAX = W_Q'(2**(W_OUT-1) - 1);
  localparam logic signed [W_Q-1:0] Q_MIN = -Q_MAX - 1;

  // Stage 1: reciprocal read, operand and case capture
  logic [W_RCP-1:0]         rcp;
  logic signed [W_DVD-1:0]  dvd1;
  dk_e                      kind1;
  logic                     done1;

  // Stage 2: product
  logic signed [W_PROD-1:0] prod;
  logic signed [W_DVD-1:0]  dvd2;
  dk_e                      kind2;
  logic                     done2;

  logic signed [W_Q-1:0]    q;
  logic signed [W_Q-1:0]    pick;
  logic signed [W_OUT-1:0]  clamped;

  dfz_recip_rom #(.W_ADDR(W_DVS), .W_DATA(W_RCP)) u_rom (
    .clk  (clk),
    .addr (dvs),
    .rdata(rcp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd1  <= '0;
      kind1 <= DK_ZERO;
      done1 <= 1'b0;
    end else begin
      dvd1  <= dvd;
      done1 <= done;
      if (dvs == '0)                kind1 <= DK_ZERO;
      else if (dvs == W_DVS'(1))    kind1 <= DK_ONE;
      else                          kind1 <= DK_TABLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod  <= '0;
      dvd2  <= '0;
      kind2 <= DK_ZERO;
      done2 <= 1'b0;
    end else begin
      prod  <= dvd1 * $signed({1'b0, rcp});
      dvd2  <= dvd1;
      kind2 <= kind1;
      done2 <= done1;
    end
  end

  always_comb begin
    q    = prod[W_PROD-1:W_RCP];
    pick = (kind2 == DK_ONE) ? W_Q'(dvd2) : q;
    if (pick > Q_MAX)      clamped = Q_MAX[W_OUT-1:0];
    else if (pick < Q_MIN) clamped = Q_MIN[W_OUT-1:0];
    else                   clamped = pick[W_OUT-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      ready  <= 1'b0;
    end else begin
      ready <= done2;
      if (done2)
        result <= (kind2 == DK_ZERO) ? {W_OUT{1'b1}} : clamped;
    end
  end

  // R4: ready lasts one clock
  a_r4_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  // R4: result only moves together with ready
  a_r4_result_hold: assert property (@(posedge clk) disable iff (rst)
    !ready |-> $stable(result));

endmodule

// File: rtl/wavg_defuzz.sv
module wavg_defuzz #(
  parameter int W_WT  = 8,
  parameter int W_SG  = 12,
  parameter int RULES = 16,
  parameter int W_RCP = 22,
  parameter int W_OUT = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_first,
  input  logic [W_WT-1:0]         in_weight,
  input  logic signed [W_SG-1:0]  in_single,
  output logic signed [W_OUT-1:0] out_result,
  output logic                    out_ready
);
  localparam int W_DVD = W_WT + 1 + W_SG + $clog2(RULES);
  localparam int W_DVS = W_WT + $clog2(RULES);

  logic signed [W_DVD-1:0] dvd;
  logic [W_DVS-1:0]        dvs;
  logic                    done;

  dfz_integ #(
    .W_WT(W_WT), .W_SG(W_SG), .RULES(RULES), .W_DVD(W_DVD), .W_DVS(W_DVS)
  ) u_integ (
    .clk   (clk),
    .rst   (rst),
    .valid (in_valid),
    .first (in_first),
    .weight(in_weight),
    .single(in_single),
    .dvd   (dvd),
    .dvs   (dvs),
    .done  (done)
  );

  dfz_divider #(
    .W_DVD(W_DVD), .W_DVS(W_DVS), .W_RCP(W_RCP), .W_OUT(W_OUT)
  ) u_div (
    .clk   (clk),
    .rst   (rst),
    .dvd   (dvd),
    .dvs   (dvs),
    .done  (done),
    .result(out_result),
    .ready (out_ready)
  );

  // R4: a closed group yields ready three clocks later
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> ##3 out_ready);

  // R5: no firing strength gives minus one
  a_r5_zero_divisor: assert property (@(posedge clk) disable iff (rst)
    (done && dvs == '0) |-> ##3 (out_result == {W_OUT{1'b1}}));

  // R6: unit strength passes the dividend through
  a_r6_unit_divisor: assert property (@(posedge clk) disable iff (rst)
    (done && dvs == W_DVS'(1)) |-> ##3 (out_result == $past(dvd[W_OUT-1:0], 3)));

endmodule

// File: tb/sim_wavg_defuzz.sv
`timescale 1ns/1ps
module sim_wavg_defuzz;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_first = 1'b0;
  logic [7:0]        in_weight = '0;
  logic signed [11:0] in_single = '0;
  logic signed [11:0] out_result;
  logic              out_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0]  gw [16];
  logic [11:0] gs [16];

  // {weight start, weight step, singleton start, singleton step}
  localparam logic [39:0] VEC [6] = '{
    {8'd255, 8'd0,   12'd100,  12'd0},
    {8'd10,  8'd13,  12'hED4,  12'd37},
    {8'd200, 8'd251, 12'd2000, 12'hF38},
    {8'd1,   8'd17,  12'h800,  12'd273},
    {8'd128, 8'd0,   12'hFFF,  12'd0},
    {8'd3,   8'd40,  12'd5,    12'd500}
  };

  always #5 clk = ~clk;

  wavg_defuzz u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_weight(in_weight), .in_single(in_single),
    .out_result(out_result), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model();
    longint dvd = 0, dvs = 0, r, q;
    for (int i = 0; i < 16; i++) begin
      dvd += longint'(gw[i]) * longint'($signed(gs[i]));
      dvs += longint'(gw[i]);
    end
    if (dvs == 0) return -1;
    if (dvs == 1) q = dvd;
    else begin
      r = ((longint'(1) <<< 23) + dvs) / (2 * dvs);
      q = (dvd * r) >>> 22;
    end
    if (q > 2047) q = 2047;
    if (q < -2048) q = -2048;
    return int'(q);
  endfunction

  function automatic void load_vec(input int v);
    for (int i = 0; i < 16; i++) begin
      gw[i] = 8'(VEC[v][39:32] + VEC[v][31:24] * i);
      gs[i] = 12'(VEC[v][23:12] + VEC[v][11:0] * i);
    end
  endfunction

  task automatic drive_group(input bit with_first, input bit gaps);
    for (int i = 0; i < 16; i++) begin
      if (gaps && i[0]) begin
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b1;
        in_weight = 8'd250; in_single = 12'sd1500;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_first = with_first && (i == 0);
      in_weight = gw[i];
      in_single = gs[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  // Called at the negedge after the last rule's accepting edge
  task automatic check_result(input string req);
    int exp = model();
    check(out_ready == 1'b0, "R4 early ready", out_ready, 0);
    @(negedge clk);
    @(negedge clk);
    check(out_ready == 1'b0, "R4 early ready", out_ready, 0);
    @(negedge clk);
    check(out_ready == 1'b1, "R4 ready at third clock", out_ready, 1);
    check(int'(out_result) == exp, req, int'(out_result), exp);
    @(negedge clk);
    check(out_ready == 1'b0, "R4 ready single pulse", out_ready, 0);
    check(int'(out_result) == exp, "R4 result held", int'(out_result), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R4 watchdog expired actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, held and just after release
    check(out_ready == 1'b0, "R1 ready in reset", out_ready, 0);
    check(out_result == 12'sd0, "R1 result in reset", int'(out_result), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(out_ready == 1'b0, "R1 ready after reset", out_ready, 0);
    check(out_result == 12'sd0, "R1 result after reset", int'(out_result), 0);

    // R3 R7: vector table
    for (int v = 0; v < 6; v++) begin
      load_vec(v);
      drive_group(1'b1, 1'b0);
      check_result("R7 weighted average");
    end

    // R5: all strengths zero
    for (int i = 0; i < 16; i++) begin gw[i] = 8'd0; gs[i] = 12'(i * 100); end
    drive_group(1'b1, 1'b0);
    check_result("R5 zero divisor gives -1");

    // R6: single unit strength
    for (int i = 0; i < 16; i++) begin gw[i] = 8'd0; gs[i] = 12'd999; end
    gw[7] = 8'd1; gs[7] = 12'hFFB;
    drive_group(1'b1, 1'b0);
    check_result("R6 unit divisor bypass");

    // R8: rounding pushes the quotient below -2048
    for (int i = 0; i < 16; i++) begin gw[i] = 8'd0; gs[i] = 12'h800; end
    gw[0] = 8'd2; gw[9] = 8'd3;
    drive_group(1'b1, 1'b0);
    check_result("R8 clamp to -2048");

    // R3: idle cycles carry junk that must be ignored
    load_vec(1);
    drive_group(1'b1, 1'b1);
    check_result("R3 invalid cycles ignored");

    // R2: a new group starts after 16 rules without a first flag
    load_vec(0);
    drive_group(1'b1, 1'b0);
    check_result("R2 group A");
    load_vec(5);
    drive_group(1'b0, 1'b0);
    check_result("R2 restart without first flag");

    // R2: a first flag abandons a partial group
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = (i == 0);
      in_weight = 8'd255; in_single = 12'sd2047;
    end
    load_vec(3);
    drive_group(1'b1, 1'b0);
    check_result("R2 first flag restarts group");

    // R3: full-scale divisor 4080
    for (int i = 0; i < 16; i++) begin gw[i] = 8'd255; gs[i] = 12'(i * 255 - 2000); end
    drive_group(1'b1, 1'b0);
    check_result("R3 maximum divisor");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule